// File: doc/BRIEF.md
# Latched IO Port with Service Interrupt

This block is a byte-wide port that sits between a peripheral and a shared data bus. It keeps one data byte in a latch. It drives that byte onto the bus through an output that either carries the latched value or floats to high impedance, and a separate enable flag shows which of the two applies. A pair of select lines forms the device decode. When the decode is true, the port is chosen.

A single mode input picks how the port works. In output mode the bus driver is always on, and the decode loads the latch. In input mode the driver is on only while the port is selected, and a strobe loads the latch. An active-low clear empties the latch, except in a cycle where the latch is loading, because loading wins over the clear. A service-request flag drives an active-low interrupt. The flag is set by the decode or by the clear, and it is reset when the strobe falls. The interrupt is active while the flag is reset or while the port is selected.

Everything runs in one system clock domain. The inputs are sampled on the rising edge, and a strobe fall is seen when the strobe was high on the previous edge and is low on the current one.

Top module: `latch_port_irq`

## Requirements
- R1: The port is selected exactly when `sel_a_n` is 0 and `sel_b` is 1. The other three combinations leave it unselected.
- R2: With `mode_out` = 1 (output mode), `drv_en` is 1 at all times. At every rising edge where the port is selected, the latch takes `din`.
- R3: With `mode_out` = 0 (input mode), `drv_en` equals the select decode. At every rising edge where `stb` is 1, the latch takes `din`.
- R4: At a rising edge where the active load source is 0 and `clr_n` is 1, the latch keeps its value. The load source is the decode in output mode and `stb` in input mode.
- R5: At a rising edge where `clr_n` is 0 and the load source is 0, the latch becomes 0. If the load source is 1 at that edge, the latch takes `din` instead.
- R6: At a rising edge where `clr_n` is 0, the service flag becomes set. `clr_n` never changes `drv_en`.
- R7: At a rising edge where the port is selected, the service flag becomes set.
- R8: A strobe fall is an edge where `stb` was 1 at the previous rising edge and is 0 at this one. At a strobe fall, the service flag is reset, unless R6 or R7 sets it at that same edge.
- R9: `int_n` is 0 when the service flag is reset or the port is selected, and 1 otherwise.
- R10: While `drv_en` is 0, every bit of `dout` is high impedance (z). While `drv_en` is 1, `dout` equals the latch.
- R11: After `rst_n` is released, the latch holds 0 and the service flag is set, so with the port unselected `int_n` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on its rising edge |
| rst_n | input | 1 | Synchronous active-low system reset |
| sel_a_n | input | 1 | Select line that must be low for the port to be selected |
| sel_b | input | 1 | Select line that must be high for the port to be selected |
| mode_out | input | 1 | 1 = output mode, 0 = input mode |
| stb | input | 1 | Strobe: loads the latch in input mode; its fall resets the service flag |
| clr_n | input | 1 | Active-low clear of the latch; also sets the service flag |
| din | input | WIDTH | Data byte to capture |
| dout | output | WIDTH | Latched byte while driven, all z otherwise |
| drv_en | output | 1 | Shows that `dout` is being driven |
| int_n | output | 1 | Active-low service interrupt |

## Verification
The assertions check four rules on every cycle:
- the load, hold and clear rules of the latch, including the priority of loading over the clear;
- the set and reset rules of the service flag at each edge;
- the driver being forced on in output mode;
- the interrupt being active whenever the port is selected.

The z value on a disabled bus cannot be checked inside the design. The same holds for how the interrupt behaves over time: it is activated by a strobe fall, then a select sets the flag again and takes the interrupt away. Only the bench's scenarios show these. They compare every output against a behavioural model on every cycle, and they walk through each mode, select and strobe combination.

// File: rtl/lpi_pkg.sv
package lpi_pkg;

    typedef enum logic {
        MODE_IN  = 1'b0,
        MODE_OUT = 1'b1
    } port_mode_e;

    // Device decode: the low-active line must be low and the high-active line high
    function automatic logic select_decode(input logic a_n, input logic b);
        return (~a_n) & b;
    endfunction

endpackage

// File: rtl/lpi_ctrl.sv
module lpi_ctrl
    import lpi_pkg::*;
(
    input  logic sel_a_n,
    input  logic sel_b,
    input  logic mode_out,
    input  logic stb,
    output logic sel,
    output logic lclk,
    output logic drv_en
);

    port_mode_e mode;

    always_comb begin
        mode = port_mode_e'(mode_out);
        sel  = select_decode(sel_a_n, sel_b);
        if (mode == MODE_OUT) begin
            lclk   = sel;
            drv_en = 1'b1;
        end else begin
            lclk   = stb;
            drv_en = sel;
        end
    end

endmodule

// File: rtl/lpi_latch.sv
module lpi_latch #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             lclk,
    input  logic             clr_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] data_q
);

    typedef struct packed {
        logic [WIDTH-1:0] data;
    } latch_state_t;

    latch_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (lclk) begin
            st_d.data = din;
        end else if (!clr_n) begin
            st_d.data = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign data_q = st_q.data;

    // R3 / R2: a high load source captures the input
    p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
        lclk |=> (data_q == $past(din)));

    // R4: no load and no clear keeps the value
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!lclk && clr_n) |=> $stable(data_q));

    // R5: a clear without a load empties the latch
    p_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!lclk && !clr_n) |=> (data_q == '0));

endmodule

// File: rtl/lpi_srq.sv
module lpi_srq (
    input  logic clk,
    input  logic rst_n,
    input  logic sel,
    input  logic stb,
    input  logic clr_n,
    output logic flag_q
);

    typedef struct packed {
        logic flag;
        logic stb_prev;
    } srq_state_t;

    srq_state_t st_d, st_q;
    logic       stb_fall;

    always_comb begin
        st_d          = st_q;
        stb_fall      = st_q.stb_prev & ~stb;
        st_d.stb_prev = stb;
        if (sel || !clr_n) begin
            st_d.flag = 1'b1;
        end else if (stb_fall) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{flag: 1'b1, stb_prev: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign flag_q = st_q.flag;

    // R7 / R6: a select or a clear sets the flag
    p_flag_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel || !clr_n) |=> flag_q);

    // R8: a strobe fall with no set source resets the flag
    p_flag_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(stb) && !stb && !sel && clr_n) |=> !flag_q);

endmodule

// File: rtl/latch_port_irq.sv
module latch_port_irq #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sel_a_n,
    input  logic             sel_b,
    input  logic             mode_out,
    input  logic             stb,
    input  logic             clr_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout,
    output logic             drv_en,
    output logic             int_n
);

    localparam logic [WIDTH-1:0] FLOAT = {WIDTH{1'bz}};

    logic             sel;
    logic             lclk;
    logic             flag_q;
    logic [WIDTH-1:0] data_q;

    lpi_ctrl u_ctrl (
        .sel_a_n (sel_a_n),
        .sel_b   (sel_b),
        .mode_out(mode_out),
        .stb     (stb),
        .sel     (sel),
        .lclk    (lclk),
        .drv_en  (drv_en)
    );

    lpi_latch #(.WIDTH(WIDTH)) u_latch (
        .clk   (clk),
        .rst_n (rst_n),
        .lclk  (lclk),
        .clr_n (clr_n),
        .din   (din),
        .data_q(data_q)
    );

    lpi_srq u_srq (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (sel),
        .stb   (stb),
        .clr_n (clr_n),
        .flag_q(flag_q)
    );

    assign int_n = flag_q & ~sel;
    assign dout  = drv_en ? data_q : FLOAT;

    // R2: output mode always drives the bus
    p_drive_outmode_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mode_out |-> drv_en);

    // R9: a selected port always shows an active interrupt
    p_int_sel_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!sel_a_n && sel_b) |-> !int_n);

endmodule

// File: tb/latch_port_irq_tb_top.sv
module latch_port_irq_tb_top;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         sel_a_n = 1'b1;
    logic         sel_b = 1'b0;
    logic         mode_out = 1'b0;
    logic         stb = 1'b0;
    logic         clr_n = 1'b1;
    logic [W-1:0] din = '0;
    logic [W-1:0] dout;
    logic         drv_en;
    logic         int_n;

    int errors = 0;
    int checks = 0;

    // behavioural reference
    logic [W-1:0] m_data = '0;
    logic         m_flag = 1'b1;
    logic         m_prev = 1'b0;

    always #5 clk = ~clk;

    latch_port_irq #(.WIDTH(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .sel_a_n(sel_a_n), .sel_b(sel_b),
        .mode_out(mode_out), .stb(stb), .clr_n(clr_n), .din(din),
        .dout(dout), .drv_en(drv_en), .int_n(int_n)
    );

    task automatic check1(input string tag, input string what,
                          input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%b expected=%b", tag, what, act, exp);
        end
    endtask

    // Drive one cycle's inputs, compare outputs, then let one edge pass
    task automatic cyc(input string tag, input logic a_n, input logic b,
                       input logic m, input logic s, input logic c,
                       input logic [W-1:0] d);
        logic sel, en, lc;
        logic [W-1:0] exp_out;
        sel_a_n = a_n; sel_b = b; mode_out = m; stb = s; clr_n = c; din = d;
        #1;
        sel = !a_n && b;
        en  = m || sel;
        exp_out = en ? m_data : {W{1'bz}};
        check1(tag, "drv_en", {{(W-1){1'b0}}, drv_en}, {{(W-1){1'b0}}, en});
        check1(tag, "int_n", {{(W-1){1'b0}}, int_n}, {{(W-1){1'b0}}, (m_flag && !sel)});
        check1(tag, "dout", dout, exp_out);
        @(posedge clk);
        lc = m ? sel : s;
        if (lc) m_data = d;
        else if (!c) m_data = '0;
        if (sel || !c) m_flag = 1'b1;
        else if (m_prev && !s) m_flag = 1'b0;
        m_prev = s;
        @(negedge clk);
    endtask

    initial begin : watchdog
        #1000000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R11: post-reset state, idle inputs
        cyc("R11", 1, 0, 0, 0, 1, 8'h11);
        cyc("R11", 1, 0, 0, 0, 1, 8'h22);
        // R1: all select combinations in input mode
        cyc("R1", 0, 0, 0, 0, 1, 8'h00);
        cyc("R1", 1, 1, 0, 0, 1, 8'h00);
        cyc("R1", 1, 0, 0, 0, 1, 8'h00);
        cyc("R1", 0, 1, 0, 0, 1, 8'h00);
        // R3: strobe loads while unselected, bus floats (R10)
        cyc("R3", 1, 0, 0, 1, 1, 8'hA5);
        cyc("R10", 1, 0, 0, 0, 1, 8'h5A);   // strobe fall: flag reset (R8)
        cyc("R8", 1, 0, 0, 0, 1, 8'h5A);    // int_n now low
        cyc("R9", 0, 1, 0, 0, 1, 8'h5A);    // select reads A5 (R4 hold), sets flag (R7)
        cyc("R7", 1, 0, 0, 0, 1, 8'h5A);    // flag set: interrupt gone
        cyc("R4", 0, 1, 0, 0, 1, 8'hFF);
        // R2: output mode drives always, decode loads
        cyc("R2", 1, 0, 1, 0, 1, 8'h3C);
        cyc("R2", 0, 1, 1, 0, 1, 8'h3C);
        cyc("R2", 1, 0, 1, 1, 1, 8'h77);    // stb ignored in output mode
        cyc("R2", 1, 0, 1, 0, 1, 8'h77);    // fall resets flag
        cyc("R4", 1, 1, 1, 0, 1, 8'h99);    // hold 3C, int_n low
        // R5: clear without load, then clear with load
        cyc("R5", 1, 0, 1, 0, 0, 8'h99);
        cyc("R5", 1, 0, 1, 0, 1, 8'h99);
        cyc("R5", 0, 1, 1, 0, 0, 8'hC3);    // decode loads over clear
        cyc("R5", 1, 0, 1, 0, 1, 8'h00);
        // R6: clear sets flag, drv_en unchanged in input mode
        cyc("R6", 1, 0, 0, 1, 1, 8'h0F);
        cyc("R6", 1, 0, 0, 0, 1, 8'h0F);    // fall resets flag
        cyc("R6", 1, 0, 0, 0, 0, 8'h0F);    // clear, drv_en stays 0
        cyc("R6", 1, 0, 0, 0, 1, 8'h0F);    // int_n high again
        cyc("R5", 1, 0, 0, 1, 0, 8'hE1);    // strobe load over clear
        cyc("R5", 0, 1, 0, 0, 1, 8'h00);    // read E1
        // R8: strobe fall while selected keeps flag set
        cyc("R8", 0, 1, 0, 1, 1, 8'h44);
        cyc("R8", 0, 1, 0, 0, 1, 8'h44);
        cyc("R8", 1, 0, 0, 0, 1, 8'h44);
        // R8: strobe fall during clear keeps flag set
        cyc("R8", 1, 0, 0, 1, 1, 8'h45);
        cyc("R8", 1, 0, 0, 0, 0, 8'h45);
        cyc("R8", 1, 0, 0, 0, 1, 8'h45);
        // R9: mixed traffic compared against the model
        for (int i = 0; i < 400; i++) begin
            cyc("R9", 1'($urandom), 1'($urandom), 1'($urandom),
                1'($urandom), ($urandom % 5) != 0, W'($urandom));
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule